// File: doc/BRIEF.md
# Wake Cause Capture Register Block

This block keeps a sticky record of what brought the device out of a low power state. Each peripheral wake source has its own bit, and two more bits record an aborted or a fallen-through low power entry. Recording starts by itself when the fast power sequencer leaves its Active state. Software can also open recording while the device is still Active, and it can block recording altogether. A recorded bit stays set until software writes a one to it.

The block also owns the wakeup interrupt, with state, enable and test controls. It owns the wake enable mask with its lock bit, and it reports the raw wake requests filtered by that mask. Software reaches all of this through a simple word-addressed write port with a combinational read port. The power sequencer supplies the "leaving Active" pulse and the abort and fall-through pulses.

Top module: `wake_cause_regs`

Register map (word address: content):
- 0: interrupt state, bit 0, write one to clear.
- 1: interrupt enable, bit 0.
- 2: interrupt test, bit 0, write only, reads 0.
- 3: wake mask lock, bit 0, write zero to clear.
- 4: wake enable mask, bits [NUM_WAKE-1:0].
- 5: wake status, read only.
- 6: capture control, bit 0 = suppress, bit 1 = software enable.
- 7: wake causes.

## Requirements
- R1: After reset the causes, interrupt state, interrupt enable, wake mask and capture control all read 0, the lock reads 1, and `intr_o` is 0.
- R2: A pulse on `leave_active_i` opens the hardware window. From then on, an enabled wake request sets cause bit i (bits [NUM_WAKE-1:0]) one clock later. Before any such pulse, with software enable 0, nothing is recorded.
- R3: While capture-control bit 0 (suppress) is 1, no cause bit is newly set, whatever the state of either window.
- R4: With capture-control bit 1 (software enable) set and suppress 0, events are recorded without a `leave_active_i` pulse.
- R5: The window stays open across events, so several causes accumulate. A write that takes suppress from 1 to 0 closes the hardware window until the next `leave_active_i` pulse.
- R6: Cause bits are sticky and write-one-to-clear at address 7. A write of zero leaves them unchanged. When an event and a clear hit the same bit in the same cycle, the bit stays set.
- R7: Address 5 reads the raw wake requests ANDed with the wake mask.
- R8: The lock at address 3 is cleared only by writing 0 to bit 0, and nothing sets it again after that. While the lock is 0, writes to the wake mask are ignored.
- R9: The interrupt state is write-one-to-clear. Writing 1 to the test register sets it. `intr_o` equals the state ANDed with the enable.
- R10: The interrupt state becomes 1 on the clock that records any cause.
- R11: A wake request whose mask bit is 0 is not recorded, even while the window is open.
- R12: A fall-through pulse sets cause bit NUM_WAKE, and an abort pulse sets bit NUM_WAKE+1. For NUM_WAKE=1 these are bits 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Word address for the write and the read |
| reg_wdata_i | input | DW | Write data |
| reg_rdata_o | output | DW | Combinational read data for reg_addr_i |
| leave_active_i | input | 1 | Pulse: the fast sequencer is leaving Active |
| wake_req_i | input | NUM_WAKE | Raw peripheral wake requests |
| abort_i | input | 1 | Pulse: low power entry aborted |
| fall_through_i | input | 1 | Pulse: low power entry fell through |
| intr_o | output | 1 | Wakeup interrupt |

## Verification
The bench targets these corner cases and the failure each one catches:
- A clear and an event that land on the same cause bit in the same cycle. A design with the wrong priority would lose the cause.
- Dropping suppress from 1 back to 0. A design that left the hardware window open would start recording again.
- Writing the wake mask after the lock has fallen. A leaky lock would let the mask change.
- A write of 1 to the lock. A design that treated the lock as a plain register would unlock it again.
- Wake requests whose mask bit is 0. These must appear neither in the status nor in the causes.
- The interrupt path, through the test write, the enable gating and the set caused by a capture.

// File: rtl/wkc_pkg.sv
// Package: register addresses and control field positions shared by the
// wake cause register block and its bench. Assumes word addressing.
package wkc_pkg;
    localparam int unsigned ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_INTR_STATE = 3'd0,
        A_INTR_EN    = 3'd1,
        A_INTR_TEST  = 3'd2,
        A_MASK_LOCK  = 3'd3,
        A_WAKE_MASK  = 3'd4,
        A_WAKE_STAT  = 3'd5,
        A_CAP_CTRL   = 3'd6,
        A_CAUSES     = 3'd7
    } wkc_addr_e;

    // capture control field positions
    localparam int unsigned CTRL_SUPPRESS = 0;
    localparam int unsigned CTRL_SW_EN    = 1;
    localparam int unsigned CTRL_W        = 2;
endpackage

// File: rtl/wkc_window.sv
// Capture window control. It holds the suppress and software enable bits and
// a hardware window flag. The flag opens on leave_active_i and closes when
// software drops suppress from 1 to 0. A pulse on leave_active_i takes
// priority over that close. Assumes leave_active_i is a single-cycle pulse.
module wkc_window
    import wkc_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ctrl_we_i,
    input  logic [CTRL_W-1:0] ctrl_wdata_i,
    input  logic              leave_active_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              cap_en_o
);
    logic              suppress_q;
    logic              sw_en_q;
    logic              hw_win_q;
    logic              suppress_fall;

    assign suppress_fall = ctrl_we_i && suppress_q && !ctrl_wdata_i[CTRL_SUPPRESS];

    // software control bits
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            suppress_q <= 1'b0;
            sw_en_q    <= 1'b0;
        end else if (ctrl_we_i) begin
            suppress_q <= ctrl_wdata_i[CTRL_SUPPRESS];
            sw_en_q    <= ctrl_wdata_i[CTRL_SW_EN];
        end
    end

    // hardware window: opened by leaving Active, closed by un-suppressing
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            hw_win_q <= 1'b0;
        end else if (leave_active_i) begin
            hw_win_q <= 1'b1;
        end else if (suppress_fall) begin
            hw_win_q <= 1'b0;
        end
    end

    always_comb begin
        ctrl_o                = '0;
        ctrl_o[CTRL_SUPPRESS] = suppress_q;
        ctrl_o[CTRL_SW_EN]    = sw_en_q;
    end

    assign cap_en_o = (hw_win_q || sw_en_q) && !suppress_q;

    // R2
    window_opens_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        leave_active_i |=> hw_win_q);

    // R5
    window_closes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (suppress_fall && !leave_active_i) |=> !hw_win_q);
endmodule

// File: rtl/wkc_causes.sv
// Sticky cause bits. Each enabled event sets its bit while capture is
// enabled. A write-one-to-clear mask removes bits, and a capture in the same
// cycle wins over the clear. recorded_o flags any recording in this cycle.
module wkc_causes #(
    parameter int unsigned NR = 3
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          cap_en_i,
    input  logic [NR-1:0] event_i,
    input  logic          clr_we_i,
    input  logic [NR-1:0] clr_mask_i,
    output logic [NR-1:0] causes_o,
    output logic          recorded_o
);
    logic [NR-1:0] cause_q;
    logic [NR-1:0] set_vec;
    logic [NR-1:0] clr_vec;

    assign set_vec = cap_en_i ? event_i : '0;
    assign clr_vec = clr_we_i ? clr_mask_i : '0;

    // per-bit sticky register, set beats clear
    for (genvar i = 0; i < NR; i++) begin : g_bit
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                cause_q[i] <= 1'b0;
            end else if (set_vec[i]) begin
                cause_q[i] <= 1'b1;
            end else if (clr_vec[i]) begin
                cause_q[i] <= 1'b0;
            end
        end
    end

    assign causes_o   = cause_q;
    assign recorded_o = |set_vec;

    // R6
    cause_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_we_i |=> (($past(cause_q) & ~cause_q) == '0));

    // R3
    no_record_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cap_en_i |=> ((cause_q & ~$past(cause_q)) == '0));
endmodule

// File: rtl/wkc_wake_mask.sv
// Wake enable mask with a write-zero-to-clear lock. While the lock is 0 the
// mask is frozen. Produces the masked wake status. The wake inputs are
// assumed to be already synchronous to clk_i.
module wkc_wake_mask #(
    parameter int unsigned NW = 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          lock_we_i,
    input  logic          lock_wbit_i,
    input  logic          mask_we_i,
    input  logic [NW-1:0] mask_wdata_i,
    input  logic [NW-1:0] wake_raw_i,
    output logic          lock_o,
    output logic [NW-1:0] mask_o,
    output logic [NW-1:0] status_o
);
    logic          lock_q;
    logic [NW-1:0] mask_q;

    // lock: only ever falls, and only on a write of 0
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            lock_q <= 1'b1;
        end else if (lock_we_i && !lock_wbit_i) begin
            lock_q <= 1'b0;
        end
    end

    // mask: writable only while unlocked
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            mask_q <= '0;
        end else if (mask_we_i && lock_q) begin
            mask_q <= mask_wdata_i;
        end
    end

    assign lock_o   = lock_q;
    assign mask_o   = mask_q;
    assign status_o = wake_raw_i & mask_q;

    // R8
    lock_stays_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lock_q |=> !lock_q);

    // R8
    mask_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lock_q |=> $stable(mask_q));
endmodule

// File: rtl/wkc_irq.sv
// Wakeup interrupt: a state bit set by hardware or by a test write and
// cleared by write-one. The hardware set wins over the clear. An enable
// bit gates the output.
module wkc_irq (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hw_set_i,
    input  logic state_we_i,
    input  logic state_wbit_i,
    input  logic en_we_i,
    input  logic en_wbit_i,
    input  logic test_we_i,
    input  logic test_wbit_i,
    output logic state_o,
    output logic en_o,
    output logic intr_o
);
    logic state_q;
    logic en_q;
    logic set_any;

    assign set_any = hw_set_i || (test_we_i && test_wbit_i);

    // interrupt state, set beats clear
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= 1'b0;
        end else if (set_any) begin
            state_q <= 1'b1;
        end else if (state_we_i && state_wbit_i) begin
            state_q <= 1'b0;
        end
    end

    // interrupt enable
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            en_q <= 1'b0;
        end else if (en_we_i) begin
            en_q <= en_wbit_i;
        end
    end

    assign state_o = state_q;
    assign en_o    = en_q;
    assign intr_o  = state_q && en_q;

    // R9
    test_sets_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (test_we_i && test_wbit_i) |=> state_q);

    // R10
    record_sets_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hw_set_i |=> state_q);
endmodule

// File: rtl/wake_cause_regs.sv
// Wake cause register block top. It decodes the word-addressed write port,
// muxes the combinational read port and wires the causes, window, wake mask
// and interrupt pieces together. Cause layout: peripheral wakes in the low
// NUM_WAKE bits, then fall-through, then abort. Assumes DW > NUM_WAKE + 2.
module wake_cause_regs
    import wkc_pkg::*;
#(
    parameter int unsigned NUM_WAKE = 1,
    parameter int unsigned DW       = 32
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                reg_we_i,
    input  logic [ADDR_W-1:0]   reg_addr_i,
    input  logic [DW-1:0]       reg_wdata_i,
    output logic [DW-1:0]       reg_rdata_o,
    input  logic                leave_active_i,
    input  logic [NUM_WAKE-1:0] wake_req_i,
    input  logic                abort_i,
    input  logic                fall_through_i,
    output logic                intr_o
);
    localparam int unsigned NR     = NUM_WAKE + 2;
    localparam int unsigned FT_BIT = NUM_WAKE;
    localparam int unsigned AB_BIT = NUM_WAKE + 1;

    logic [7:0]          wsel;
    logic [CTRL_W-1:0]   ctrl;
    logic                cap_en;
    logic [NR-1:0]       events;
    logic [NR-1:0]       causes;
    logic                recorded;
    logic                lock;
    logic [NUM_WAKE-1:0] wmask;
    logic [NUM_WAKE-1:0] wstat;
    logic                irq_state;
    logic                irq_en;
    logic                wdata_unused;

    assign wdata_unused = ^reg_wdata_i[DW-1:NR];

    // one write select per address
    for (genvar a = 0; a < 8; a++) begin : g_wsel
        assign wsel[a] = reg_we_i && (reg_addr_i == ADDR_W'(a));
    end

    // event vector in cause layout
    always_comb begin
        events                   = '0;
        events[NUM_WAKE-1:0]     = wstat;
        events[FT_BIT]           = fall_through_i;
        events[AB_BIT]           = abort_i;
    end

    wkc_window u_window (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .ctrl_we_i      (wsel[A_CAP_CTRL]),
        .ctrl_wdata_i   (reg_wdata_i[CTRL_W-1:0]),
        .leave_active_i (leave_active_i),
        .ctrl_o         (ctrl),
        .cap_en_o       (cap_en)
    );

    wkc_causes #(.NR(NR)) u_causes (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cap_en_i   (cap_en),
        .event_i    (events),
        .clr_we_i   (wsel[A_CAUSES]),
        .clr_mask_i (reg_wdata_i[NR-1:0]),
        .causes_o   (causes),
        .recorded_o (recorded)
    );

    wkc_wake_mask #(.NW(NUM_WAKE)) u_mask (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .lock_we_i    (wsel[A_MASK_LOCK]),
        .lock_wbit_i  (reg_wdata_i[0]),
        .mask_we_i    (wsel[A_WAKE_MASK]),
        .mask_wdata_i (reg_wdata_i[NUM_WAKE-1:0]),
        .wake_raw_i   (wake_req_i),
        .lock_o       (lock),
        .mask_o       (wmask),
        .status_o     (wstat)
    );

    wkc_irq u_irq (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .hw_set_i     (recorded),
        .state_we_i   (wsel[A_INTR_STATE]),
        .state_wbit_i (reg_wdata_i[0]),
        .en_we_i      (wsel[A_INTR_EN]),
        .en_wbit_i    (reg_wdata_i[0]),
        .test_we_i    (wsel[A_INTR_TEST]),
        .test_wbit_i  (reg_wdata_i[0]),
        .state_o      (irq_state),
        .en_o         (irq_en),
        .intr_o       (intr_o)
    );

    // combinational read mux
    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            A_INTR_STATE: reg_rdata_o[0]              = irq_state;
            A_INTR_EN:    reg_rdata_o[0]              = irq_en;
            A_MASK_LOCK:  reg_rdata_o[0]              = lock;
            A_WAKE_MASK:  reg_rdata_o[NUM_WAKE-1:0]   = wmask;
            A_WAKE_STAT:  reg_rdata_o[NUM_WAKE-1:0]   = wstat;
            A_CAP_CTRL:   reg_rdata_o[CTRL_W-1:0]     = ctrl;
            A_CAUSES:     reg_rdata_o[NR-1:0]         = causes;
            default:      reg_rdata_o                 = '0;
        endcase
    end

    // R9
    intr_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_en |-> !intr_o);
endmodule

// File: tb/test_wake_cause_regs.sv
`timescale 1ns/1ps
module test_wake_cause_regs;
    import wkc_pkg::*;

    localparam int unsigned NUM_WAKE = 1;
    localparam int unsigned DW       = 32;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                we = 1'b0;
    logic [ADDR_W-1:0]   addr = '0;
    logic [DW-1:0]       wdata = '0;
    logic [DW-1:0]       rdata;
    logic                leave = 1'b0;
    logic [NUM_WAKE-1:0] wake = '0;
    logic                abort_p = 1'b0;
    logic                ft_p = 1'b0;
    logic                intr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    wake_cause_regs #(.NUM_WAKE(NUM_WAKE), .DW(DW)) i_wake_cause_regs (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .reg_we_i       (we),
        .reg_addr_i     (addr),
        .reg_wdata_i    (wdata),
        .reg_rdata_o    (rdata),
        .leave_active_i (leave),
        .wake_req_i     (wake),
        .abort_i        (abort_p),
        .fall_through_i (ft_p),
        .intr_o         (intr)
    );

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(wkc_addr_e a, logic [DW-1:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(wkc_addr_e a, output logic [DW-1:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    // sel: 0 leave, 1 wake, 2 abort, 3 fall-through
    task automatic pulse(int sel);
        @(negedge clk);
        case (sel)
            0: leave = 1'b1;
            1: wake = '1;
            2: abort_p = 1'b1;
            default: ft_p = 1'b1;
        endcase
        @(negedge clk);
        leave = 1'b0; wake = '0; abort_p = 1'b0; ft_p = 1'b0;
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        rd(A_CAUSES, v);     check("R1 causes", v, 0);
        rd(A_INTR_STATE, v); check("R1 intr state", v, 0);
        rd(A_MASK_LOCK, v);  check("R1 lock", v, 1);
        rd(A_WAKE_MASK, v);  check("R1 mask", v, 0);
        rd(A_CAP_CTRL, v);   check("R1 ctrl", v, 0);
        check("R1 intr_o", DW'(intr), 0);
    endtask

    task automatic t_status();
        logic [DW-1:0] v;
        wr(A_WAKE_MASK, 1);
        wake = 1'b1;
        rd(A_WAKE_STAT, v); check("R7 status masked in", v, 1);
        wr(A_WAKE_MASK, 0);
        rd(A_WAKE_STAT, v); check("R7 status masked out", v, 0);
        wr(A_WAKE_MASK, 1);
        @(negedge clk);
        wake = 1'b0;
        rd(A_CAUSES, v); check("R2 nothing before exit", v, 0);
    endtask

    task automatic t_hw_window();
        logic [DW-1:0] v;
        pulse(0);
        pulse(1);
        rd(A_CAUSES, v);     check("R2 wake cause", v, 3'b001);
        rd(A_INTR_STATE, v); check("R10 intr set on record", v, 1);
        pulse(2);
        rd(A_CAUSES, v);     check("R12 abort bit", v, 3'b101);
        pulse(3);
        rd(A_CAUSES, v);     check("R5 accumulate fall-through", v, 3'b111);
    endtask

    task automatic t_w1c();
        logic [DW-1:0] v;
        wr(A_CAUSES, 3'b010);
        rd(A_CAUSES, v); check("R6 w1c one bit", v, 3'b101);
        wr(A_CAUSES, 0);
        rd(A_CAUSES, v); check("R6 write zero no effect", v, 3'b101);
        @(negedge clk);
        abort_p = 1'b1; we = 1'b1; addr = A_CAUSES; wdata = 3'b100;
        @(negedge clk);
        abort_p = 1'b0; we = 1'b0; wdata = '0;
        rd(A_CAUSES, v); check("R6 capture beats clear", v, 3'b101);
        wr(A_CAUSES, 3'b111);
        rd(A_CAUSES, v); check("R6 clear all", v, 0);
    endtask

    task automatic t_disable();
        logic [DW-1:0] v;
        wr(A_CAP_CTRL, 1);
        pulse(2);
        rd(A_CAUSES, v); check("R3 suppressed abort", v, 0);
        wr(A_CAP_CTRL, 0);
        pulse(3);
        pulse(1);
        rd(A_CAUSES, v); check("R5 hw window closed", v, 0);
    endtask

    task automatic t_sw_en();
        logic [DW-1:0] v;
        wr(A_CAP_CTRL, 2);
        pulse(3);
        rd(A_CAUSES, v); check("R4 sw enable records", v, 3'b010);
        wr(A_CAP_CTRL, 3);
        pulse(2);
        rd(A_CAUSES, v); check("R3 suppress over sw enable", v, 3'b010);
        wr(A_CAP_CTRL, 2);
        wr(A_CAUSES, 3'b111);
        wr(A_WAKE_MASK, 0);
        pulse(1);
        rd(A_CAUSES, v); check("R11 masked wake ignored", v, 0);
        wr(A_CAP_CTRL, 0);
    endtask

    task automatic t_irq();
        logic [DW-1:0] v;
        wr(A_INTR_STATE, 1);
        rd(A_INTR_STATE, v); check("R9 state w1c", v, 0);
        wr(A_INTR_EN, 1);
        wr(A_INTR_TEST, 1);
        rd(A_INTR_STATE, v); check("R9 test sets state", v, 1);
        check("R9 intr_o enabled", DW'(intr), 1);
        wr(A_INTR_EN, 0);
        check("R9 intr_o gated", DW'(intr), 0);
        wr(A_INTR_STATE, 1);
        rd(A_INTR_STATE, v); check("R9 state cleared", v, 0);
        wr(A_CAP_CTRL, 2);
        pulse(2);
        rd(A_INTR_STATE, v); check("R10 abort raises state", v, 1);
        wr(A_CAP_CTRL, 0);
    endtask

    task automatic t_lock();
        logic [DW-1:0] v;
        wr(A_MASK_LOCK, 1);
        rd(A_MASK_LOCK, v); check("R8 write 1 keeps lock", v, 1);
        wr(A_MASK_LOCK, 0);
        rd(A_MASK_LOCK, v); check("R8 write 0 clears lock", v, 0);
        wr(A_WAKE_MASK, 1);
        rd(A_WAKE_MASK, v); check("R8 mask frozen", v, 0);
        wr(A_MASK_LOCK, 1);
        rd(A_MASK_LOCK, v); check("R8 lock cannot reset", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_status();
        t_hw_window();
        t_w1c();
        t_disable();
        t_sw_en();
        t_irq();
        t_lock();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule